// File: doc/BRIEF.md
# Switching-Activity Thermal Load Generator

This block turns spare logic into controlled heat for thermal qualification of a board. It has three load sections. A long flip-flop chain takes in a repeating bit pattern. A cascade of XOR mixing stages reads the head of that chain. A dual-port memory is written and read on every cycle with words from a free-running LFSR. A 2-bit pattern select sets how densely the chain toggles and can also halt every load section. Each section has its own enable. The XOR cascade can run with registers between stages, which keeps it quiet, or without them, which lets glitches ripple through the cascade and raise power further.

All three sections are folded into one registered checksum output. Synthesis then cannot remove any of them. A slow LED output toggles from a free-running counter, so an operator can see that the clock is alive. Drive the controls from switches or a register, watch the LED, and let the checksum reach a pin.

Top module: `heat_load_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets synchronously. After that edge, `checksum` and `led` are 0, the chain and the XOR stage registers are 0, the pattern phase is 0, and the LFSR holds its seed.
- R2: A 4-bit pattern phase advances by one on each cycle the chain shifts. The bit entering chain flop 0 on that cycle depends on `pat_sel` and the phase: `01` gives 1 only when the phase is 0, `10` gives 1 when the phase mod 4 is 0, and `11` gives 1 when the phase is even.
- R3: With `pat_sel` = `11` and the chain enabled, every chain flop changes state on every clock. Once the chain is full, consecutive tail words are bitwise complements.
- R4: With `pat_sel` = `00`, the chain, the pattern phase, the XOR stage registers, the LFSR, the memory and its read register all hold their values. The checksum stays constant from the second such cycle on.
- R5: A section whose enable is low holds its state and adds 0 to the checksum. The enables are `chain_en`, `xor_en` and `mem_en`.
- R6: Each XOR stage maps a word x to x XOR (x rotated left by one bit). With `xor_pipe_en` low, the cascade output is that map applied `XOR_STAGES` times to the current chain head word (chain flops 15..0) within the same cycle.
- R7: With `xor_pipe_en` high and the cascade running continuously, its output equals the same multi-stage map of the head word from `XOR_STAGES` cycles earlier.
- R8: The LFSR is a 16-bit right-shifting Galois generator with feedback mask 0xB400 and seed 0xACE1. On each memory cycle it steps. Its current word is written at the address given by its low bits, and the read address trails that address by one cycle. The read word therefore equals the LFSR word from two cycles earlier.
- R9: `checksum` is registered. Its value after a clock edge is the XOR of the state before that edge: the tail word (bit 15 = last chain flop), the XOR cascade output and the memory read word, each folded to `CK_W` bits.
- R10: `led` equals bit `LED_BIT` of a counter that counts every clock after reset, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_sel | input | 2 | Pattern select; 00 halts all load sections |
| chain_en | input | 1 | Chain section enable |
| xor_en | input | 1 | XOR cascade section enable |
| xor_pipe_en | input | 1 | Register between XOR stages when high |
| mem_en | input | 1 | Memory section enable |
| led | output | 1 | Heartbeat from counter bit LED_BIT |
| checksum | output | CK_W | Registered fold of all section outputs |

## Verification
Each checksum is due one cycle after the state it folds. The state in turn depends on the chain bit shifted in at the edge before, on `XOR_STAGES` older head words when the cascade is pipelined, and on the LFSR word from two cycles earlier for memory reads. The bench samples 1 ns after each rising edge. It keeps a per-edge history of head words and LFSR words and compares against the entry matching each latency. A pipelined XOR term is compared only after `XOR_STAGES` unbroken pipelined cycles, and a memory term only after two unbroken memory cycles. Until then that checksum is not scored. The LED is compared against the bench's own count of edges since reset.

// File: rtl/heat_pkg.sv
// Shared types for the thermal load generator.
package heat_pkg;

    // Pattern select encoding; PAT_OFF halts every load section.
    typedef enum logic [1:0] {
        PAT_OFF     = 2'b00,
        PAT_SPARSE  = 2'b01,
        PAT_QUARTER = 2'b10,
        PAT_ALT     = 2'b11
    } pat_mode_e;

endpackage

// File: rtl/heat_pattern_chain.sv
// Long shift chain fed by a repeating pattern.
// Assumes CHAIN_LEN >= HEAD_W, CHAIN_LEN >= TAIL_W and SPARSE_PERIOD a power of two >= 4.
// Flop 0 takes the new bit; the tail word's MSB is the last flop.
module heat_pattern_chain
    import heat_pkg::*;
#(
    parameter int CHAIN_LEN     = 1024,
    parameter int SPARSE_PERIOD = 16,
    parameter int HEAD_W        = 16,
    parameter int TAIL_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  pat_mode_e         mode,
    output logic [HEAD_W-1:0] head_word,
    output logic [TAIL_W-1:0] tail_word,
    output logic              head_bit
);
    localparam int PH_W = $clog2(SPARSE_PERIOD);

    logic [CHAIN_LEN-1:0] chain_q;
    logic [PH_W-1:0]      phase_q;
    logic                 inj_bit;

    // Choose the bit injected this cycle from mode and phase.
    always_comb begin
        case (mode)
            PAT_SPARSE:  inj_bit = (phase_q == '0);
            PAT_QUARTER: inj_bit = (phase_q[1:0] == 2'b00);
            PAT_ALT:     inj_bit = ~phase_q[0];
            default:     inj_bit = 1'b0;
        endcase
    end

    // Advance the phase and shift the chain on each running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            phase_q <= '0;
        end else if (run) begin
            chain_q <= {chain_q[CHAIN_LEN-2:0], inj_bit};
            phase_q <= phase_q + 1'b1;
        end
    end

    assign head_word = chain_q[HEAD_W-1:0];
    assign tail_word = chain_q[CHAIN_LEN-1 -: TAIL_W];
    assign head_bit  = chain_q[0];

endmodule

// File: rtl/heat_xor_cascade.sv
// Cascade of XOR mixing stages, each x ^ rotl(x,1).
// With pipe_on the stages are separated by registers; without it the
// combinational path runs through all stages and can glitch freely.
// Assumes WIDTH >= 2, STAGES >= 1.
module heat_xor_cascade #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pipe_on,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar k = 0; k < STAGES; k++) begin : g_stg
        logic [WIDTH-1:0] s_in;
        logic [WIDTH-1:0] s_mix;
        logic [WIDTH-1:0] s_q;

        if (k == 0) begin : g_first
            assign s_in = din;
        end else begin : g_next
            assign s_in = pipe_on ? g_stg[k-1].s_q : g_stg[k-1].s_mix;
        end

        assign s_mix = s_in ^ {s_in[WIDTH-2:0], s_in[WIDTH-1]};

        // Stage register, loaded on every running cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)   s_q <= '0;
            else if (run) s_q <= s_mix;
        end
    end

    assign dout = pipe_on ? g_stg[STAGES-1].s_q : g_stg[STAGES-1].s_mix;

endmodule

// File: rtl/heat_mem_churn.sv
// Dual-port memory churned by an LFSR: each running cycle writes the
// LFSR word at its low-bit address and reads the address written one
// cycle before (read-first). Memory contents are not reset.
module heat_mem_churn #(
    parameter int              LFSR_W = 16,
    parameter int              ADDR_W = 6,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [LFSR_W-1:0] lfsr_word,
    output logic [LFSR_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LFSR_W-1:0] ram [DEPTH];
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] lfsr_nxt;
    logic [LFSR_W-1:0] rd_q;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr_q;

    assign lfsr_nxt = (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
    assign waddr    = lfsr_q[ADDR_W-1:0];

    // Write port: current LFSR word every running cycle.
    always_ff @(posedge clk) begin
        if (run) ram[waddr] <= lfsr_q;
    end

    // Step LFSR, trail the address by one cycle, register the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q  <= SEED;
            raddr_q <= '0;
            rd_q    <= '0;
        end else if (run) begin
            lfsr_q  <= lfsr_nxt;
            raddr_q <= waddr;
            rd_q    <= ram[raddr_q];
        end
    end

    assign lfsr_word = lfsr_q;
    assign rd_word   = rd_q;

endmodule

// File: rtl/heat_load_top.sv
// Top of the thermal load generator: chain, XOR cascade and memory churn,
// all folded into a registered checksum, plus a heartbeat LED.
// Assumes CHAIN_LEN >= XOR_W and CHAIN_LEN >= CK_W, LED_BIT >= 1.
module heat_load_top
    import heat_pkg::*;
#(
    parameter int                CHAIN_LEN     = 1024,
    parameter int                SPARSE_PERIOD = 16,
    parameter int                XOR_W         = 16,
    parameter int                XOR_STAGES    = 3,
    parameter int                LFSR_W        = 16,
    parameter int                MEM_AW        = 6,
    parameter logic [LFSR_W-1:0] LFSR_SEED     = 16'hACE1,
    parameter logic [LFSR_W-1:0] LFSR_TAPS     = 16'hB400,
    parameter int                CK_W          = 16,
    parameter int                LED_BIT       = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      pat_sel,
    input  logic            chain_en,
    input  logic            xor_en,
    input  logic            xor_pipe_en,
    input  logic            mem_en,
    output logic            led,
    output logic [CK_W-1:0] checksum
);
    localparam int LED_CNT_W = LED_BIT + 1;

    pat_mode_e         mode;
    logic              load_on;
    logic              chain_run;
    logic              xor_run;
    logic              mem_run;
    logic [XOR_W-1:0]  head_word;
    logic [CK_W-1:0]   tail_word;
    logic              chain_head_bit;
    logic [XOR_W-1:0]  xor_out;
    logic [LFSR_W-1:0] lfsr_word;
    logic [LFSR_W-1:0] rd_word;
    logic [LED_CNT_W-1:0] led_cnt;
    logic [CK_W-1:0]   ck_next;

    assign mode      = pat_mode_e'(pat_sel);
    assign load_on   = (mode != PAT_OFF);
    assign chain_run = load_on & chain_en;
    assign xor_run   = load_on & xor_en;
    assign mem_run   = load_on & mem_en;

    heat_pattern_chain #(
        .CHAIN_LEN    (CHAIN_LEN),
        .SPARSE_PERIOD(SPARSE_PERIOD),
        .HEAD_W       (XOR_W),
        .TAIL_W       (CK_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (chain_run),
        .mode     (mode),
        .head_word(head_word),
        .tail_word(tail_word),
        .head_bit (chain_head_bit)
    );

    heat_xor_cascade #(
        .WIDTH (XOR_W),
        .STAGES(XOR_STAGES)
    ) u_xor (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (xor_run),
        .pipe_on(xor_pipe_en),
        .din    (head_word),
        .dout   (xor_out)
    );

    heat_mem_churn #(
        .LFSR_W(LFSR_W),
        .ADDR_W(MEM_AW),
        .SEED  (LFSR_SEED),
        .TAPS  (LFSR_TAPS)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mem_run),
        .lfsr_word(lfsr_word),
        .rd_word  (rd_word)
    );

    // Fold an XOR-width word onto the checksum width.
    function automatic logic [CK_W-1:0] fold_x(input logic [XOR_W-1:0] w);
        logic [CK_W-1:0] r;
        r = '0;
        for (int i = 0; i < XOR_W; i++) r[i % CK_W] = r[i % CK_W] ^ w[i];
        return r;
    endfunction

    // Fold an LFSR-width word onto the checksum width.
    function automatic logic [CK_W-1:0] fold_m(input logic [LFSR_W-1:0] w);
        logic [CK_W-1:0] r;
        r = '0;
        for (int i = 0; i < LFSR_W; i++) r[i % CK_W] = r[i % CK_W] ^ w[i];
        return r;
    endfunction

    // Combine the enabled sections into the next checksum value.
    always_comb begin
        ck_next = '0;
        if (chain_en) ck_next = ck_next ^ tail_word;
        if (xor_en)   ck_next = ck_next ^ fold_x(xor_out);
        if (mem_en)   ck_next = ck_next ^ fold_m(rd_word);
    end

    // Register the checksum.
    always_ff @(posedge clk) begin
        if (!rst_n) checksum <= '0;
        else        checksum <= ck_next;
    end

    // Free-running heartbeat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) led_cnt <= '0;
        else        led_cnt <= led_cnt + 1'b1;
    end

    assign led = led_cnt[LED_BIT];

endmodule

// File: rtl/heat_load_chk.sv
// Assertion checker for heat_load_top, attached with bind below.
module heat_load_chk #(
    parameter int LFSR_W  = 16,
    parameter int LED_BIT = 25,
    parameter int CK_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pat_sel,
    input logic              chain_en,
    input logic              mem_en,
    input logic              led,
    input logic [CK_W-1:0]   checksum,
    input logic [LED_BIT:0]  led_cnt,
    input logic              chain_head_bit,
    input logic [LFSR_W-1:0] lfsr_word,
    input logic [LFSR_W-1:0] rd_word
);
    logic alt_run;
    logic mem_go;

    assign alt_run = (pat_sel == 2'b11) && chain_en;
    assign mem_go  = (pat_sel != 2'b00) && mem_en;

    // R1: a reset edge clears the checksum and the LED.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (checksum == '0 && led == 1'b0));

    // R3: alternating pattern toggles the head flop every cycle.
    a_r3_alt_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alt_run) && $past(alt_run, 2) && $past(rst_n) && $past(rst_n, 2))
        |-> (chain_head_bit != $past(chain_head_bit)));

    // R4: pattern 00 freezes load state.
    a_r4_off_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel == 2'b00) |=> ($stable(lfsr_word) && $stable(chain_head_bit) && $stable(rd_word)));

    // R8: read word is the LFSR word of two cycles earlier.
    a_r8_read_trails: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_go) && $past(mem_go, 2) && $past(rst_n) && $past(rst_n, 2))
        |-> (rd_word == $past(lfsr_word, 2)));

    // R10: the LED only changes when the counter's low bits wrap.
    a_r10_led_period: assert property (@(posedge clk) disable iff (!rst_n)
        (led != $past(led)) |-> (led_cnt[LED_BIT-1:0] == '0));

endmodule

bind heat_load_top heat_load_chk #(
    .LFSR_W (LFSR_W),
    .LED_BIT(LED_BIT),
    .CK_W   (CK_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pat_sel       (pat_sel),
    .chain_en      (chain_en),
    .mem_en        (mem_en),
    .led           (led),
    .checksum      (checksum),
    .led_cnt       (led_cnt),
    .chain_head_bit(chain_head_bit),
    .lfsr_word     (lfsr_word),
    .rd_word       (rd_word)
);

// File: tb/tb_heat_load_top.sv
// Bench for heat_load_top: vector table walked by one loop, then directed tests.
module tb_heat_load_top;
    localparam int CL = 48;
    localparam int LB = 3;
    localparam int NS = 3;
    localparam int NV = 10;

    // Vector fields: [13:12] pat, [11] chain, [10] xor, [9] pipe, [8] mem, [7:0] cycles
    localparam logic [13:0] VEC [NV] = '{
        {2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'd40},
        {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'd40},
        {2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'd40},
        {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 8'd10},
        {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 8'd30},
        {2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 8'd30},
        {2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 8'd40},
        {2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'd30},
        {2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 8'd20},
        {2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'd40}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pat_sel = 2'b00;
    logic        chain_en = 1'b0;
    logic        xor_en = 1'b0;
    logic        xor_pipe_en = 1'b0;
    logic        mem_en = 1'b0;
    logic        led;
    logic [15:0] checksum;

    int n_checks = 0;
    int n_errors = 0;

    // Reference state (per requirements)
    logic [CL-1:0] rchain;
    int            rphase;
    logic [15:0]   hist [NS+1];
    logic [15:0]   lh [3];
    logic [15:0]   rl;
    int            xrun;
    int            mrun;
    int            cyc;

    heat_load_top #(
        .CHAIN_LEN(CL),
        .LED_BIT  (LB)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pat_sel    (pat_sel),
        .chain_en   (chain_en),
        .xor_en     (xor_en),
        .xor_pipe_en(xor_pipe_en),
        .mem_en     (mem_en),
        .led        (led),
        .checksum   (checksum)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] mix_n(input logic [15:0] x);
        logic [15:0] y;
        y = x;
        for (int k = 0; k < NS; k++) y = y ^ {y[14:0], y[15]};
        return y;
    endfunction

    function automatic logic [15:0] lfsr_step(input logic [15:0] x);
        return (x >> 1) ^ (x[0] ? 16'hB400 : 16'h0000);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string pick_tag();
        if (pat_sel == 2'b00) return "R4";
        if (mem_en && !chain_en && !xor_en) return "R8";
        if (xor_en && xor_pipe_en && !mem_en) return "R7";
        if (xor_en && !mem_en) return "R6";
        if (chain_en && !xor_en && !mem_en) return "R2";
        if (!chain_en || !xor_en || !mem_en) return "R5";
        return "R9";
    endfunction

    task automatic ref_reset();
        rchain = '0;
        rphase = 0;
        for (int i = 0; i <= NS; i++) hist[i] = '0;
        rl = 16'hACE1;
        for (int i = 0; i < 3; i++) lh[i] = 16'hACE1;
        xrun = 0;
        mrun = 0;
        cyc  = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        ref_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock edge: predict checksum from pre-edge reference state, then update it.
    task automatic step();
        logic [15:0] exp_ck;
        logic        ok;
        logic        act;
        logic        inj;
        string       tag;
        @(posedge clk);
        #1;
        tag = pick_tag();
        ok = 1'b1;
        exp_ck = '0;
        if (chain_en) exp_ck = exp_ck ^ rchain[CL-1 -: 16];
        if (xor_en) begin
            if (!xor_pipe_en)   exp_ck = exp_ck ^ mix_n(hist[0]);
            else if (xrun >= NS) exp_ck = exp_ck ^ mix_n(hist[NS]);
            else ok = 1'b0;
        end
        if (mem_en) begin
            if (mrun >= 2) exp_ck = exp_ck ^ lh[2];
            else ok = 1'b0;
        end
        act = (pat_sel != 2'b00);
        if (act && chain_en) begin
            case (pat_sel)
                2'b01:   inj = (rphase == 0);
                2'b10:   inj = (rphase % 4 == 0);
                default: inj = (rphase % 2 == 0);
            endcase
            rchain = {rchain[CL-2:0], inj};
            rphase = (rphase + 1) % 16;
        end
        for (int i = NS; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = rchain[15:0];
        if (act && xor_en && xor_pipe_en) xrun++;
        else xrun = 0;
        if (act && mem_en) begin
            rl = lfsr_step(rl);
            mrun++;
        end else begin
            mrun = 0;
        end
        lh[2] = lh[1];
        lh[1] = lh[0];
        lh[0] = rl;
        cyc++;
        if (ok) check(tag, checksum, exp_ck);
        check("R10", {15'd0, led}, {15'd0, 1'(cyc >> LB)});
    endtask

    task automatic set_cfg(input logic [13:0] v);
        pat_sel     = v[13:12];
        chain_en    = v[11];
        xor_en      = v[10];
        xor_pipe_en = v[9];
        mem_en      = v[8];
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        logic [15:0] prev;
        ref_reset();
        do_reset();
        #1;
        // R1: reset state
        check("R1", checksum, 16'h0000);
        check("R1", {15'd0, led}, 16'h0000);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v]);
            run_n(int'(VEC[v][7:0]));
        end

        // R2: window populations for each density
        do_reset();
        set_cfg({2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0});
        run_n(CL + 5);
        check("R2", 16'($countones(checksum)), 16'd1);
        do_reset();
        set_cfg({2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0});
        run_n(CL + 3);
        check("R2", 16'($countones(checksum)), 16'd4);

        // R3: alternating pattern gives complementary consecutive tails
        do_reset();
        set_cfg({2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0});
        run_n(CL + 2);
        for (int i = 0; i < 4; i++) begin
            prev = checksum;
            step();
            check("R3", checksum ^ prev, 16'hFFFF);
        end

        // R4: pattern 00 holds the checksum with all sections enabled
        set_cfg({2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 8'd0});
        run_n(6);
        pat_sel = 2'b00;
        step();
        prev = checksum;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R4", checksum, prev);
        end

        // R5: all section enables low -> checksum zero, state held
        set_cfg({2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0});
        run_n(3);
        check("R5", checksum, 16'h0000);
        // re-enable chain only: tail unchanged by the idle period
        chain_en = 1'b1;
        pat_sel  = 2'b00;
        step();
        prev = checksum;
        step();
        check("R5", checksum, prev);

        // R1: reset in the middle of activity
        set_cfg({2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 8'd0});
        run_n(20);
        do_reset();
        #1;
        check("R1", checksum, 16'h0000);
        check("R1", {15'd0, led}, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule